// File: doc/BRIEF.md
# Floating-point data class tester

This block decides whether a binary floating-point operand belongs to any of a chosen set of value classes. One operand arrives per cycle on a 128-bit bus together with a format select (32-bit, 64-bit or 128-bit encoding) and a 7-bit class mask. The block decodes the exponent and fraction of the selected format, marks which of seven classes the value belongs to (NaN, positive or negative infinity, positive or negative zero, positive or negative subnormal), and raises a match flag when the operand's class is enabled in the mask.

The result is a 4-bit condition field that a branch or select unit can consume directly: one bit carries the match, a separate bit carries the operand's sign, and the remaining two bits are always zero. Normal numbers belong to no class, so enabling every class turns the match flag into a "not normal" test; the sign bit then lets a consumer build positive-normal and negative-normal tests without a second pass. Quiet and signaling NaNs fall into the single NaN class. The condition field is held in one output register that loads only when an operand is presented.

Top module: `fpc_probe`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid` is 0 and `cond` is 4'b0000.
- R2: An operand presented with `in_valid` high at a rising clock edge produces `out_valid` high and its condition field on `cond` after that edge, one cycle of latency; back-to-back operands give back-to-back results in order.
- R3: A clock edge with `in_valid` low leaves `cond` unchanged and drives `out_valid` low.
- R4: `fmt` selects the encoding: 2'd0 is 32-bit (operand[31:0], exponent 8 bits, fraction 23 bits), 2'd1 is 64-bit (operand[63:0], exponent 11, fraction 52), 2'd2 and 2'd3 are 128-bit (exponent 15, fraction 112); bits above the selected width have no effect on the result.
- R5: Classes follow the IEEE 754 field rules: exponent all ones with a nonzero fraction is NaN, all ones with a zero fraction is infinity, all zeros with a zero fraction is zero, all zeros with a nonzero fraction is subnormal; any other exponent is a normal number and belongs to no class.
- R6: Mask bits enable classes as follows: bit 6 NaN, bit 5 positive infinity, bit 4 negative infinity, bit 3 positive zero, bit 2 negative zero, bit 1 positive subnormal, bit 0 negative subnormal; the match flag is 1 when the operand's class bit is set in the mask.
- R7: The condition field is ordered {LT, GT, EQ, SO} from `cond[3]` down to `cond[0]`; the operand's sign bit is placed in `cond[3]` whatever the mask and class.
- R8: The match flag is placed in `cond[1]`; `cond[2]` and `cond[0]` are always 0.
- R9: With mask 7'h7F the match flag is 0 exactly for normal numbers; with mask 7'h00 it is always 0.
- R10: Quiet and signaling NaNs (fraction MSB set or clear) both match mask bit 6 and no other mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| fmt | input | 2 | Encoding select: 0 = 32-bit, 1 = 64-bit, 2 or 3 = 128-bit |
| operand | input | 128 | Operand, narrower encodings in the low bits |
| class_mask | input | 7 | Enabled classes, one bit per class |
| out_valid | output | 1 | Condition field updated on the last edge |
| cond | output | 4 | {sign, 0, match, 0} |

## Verification
Every result comes from a single register, so the condition field and `out_valid` for an operand driven just after edge N are due after edge N+1; the driver applies stimulus shortly after a rising edge and pushes the expected field into a queue, and the monitor samples a few nanoseconds after each rising edge, popping one item for every cycle with `out_valid` high. On cycles with `out_valid` low the monitor instead compares `cond` with the last popped value, which checks that idle edges hold the register. The queue must be empty once the stimulus ends, which catches dropped or extra results.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int OP_W    = 128;
    localparam int NUM_FMT = 3;
    localparam int CLASS_W = 7;
    localparam int COND_W  = 4;
    localparam int FMT_SEL_W = $clog2(NUM_FMT + 1);

    // Class vector / mask bit positions
    localparam int CL_NAN  = 6;
    localparam int CL_PINF = 5;
    localparam int CL_NINF = 4;
    localparam int CL_PZER = 3;
    localparam int CL_NZER = 2;
    localparam int CL_PSUB = 1;
    localparam int CL_NSUB = 0;

    // Condition field bit positions
    localparam int CF_LT = 3;
    localparam int CF_GT = 2;
    localparam int CF_EQ = 1;
    localparam int CF_SO = 0;

    typedef enum logic [FMT_SEL_W-1:0] {
        FMT_W32  = 2'd0,
        FMT_W64  = 2'd1,
        FMT_W128 = 2'd2,
        FMT_WALT = 2'd3
    } fmt_e;

    function automatic int fmt_exp_w(input int idx);
        case (idx)
            0:       return 8;
            1:       return 11;
            default: return 15;
        endcase
    endfunction

    function automatic int fmt_frac_w(input int idx);
        case (idx)
            0:       return 23;
            1:       return 52;
            default: return 112;
        endcase
    endfunction

    typedef struct packed {
        logic              vld;
        logic [COND_W-1:0] cond;
    } probe_state_t;

endpackage

// File: rtl/fpc_field_decode.sv
module fpc_field_decode
    import fpc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
    input  logic [TOT_W-1:0]   word,
    output logic [CLASS_W-1:0] cls,
    output logic               sign
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic exp_ones, exp_zero, frac_any;

    always_comb begin
        sign     = word[TOT_W-1];
        exp_f    = word[TOT_W-2:FRAC_W];
        frac_f   = word[FRAC_W-1:0];
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        frac_any = |frac_f;

        cls          = '0;
        cls[CL_NAN]  = exp_ones & frac_any;
        cls[CL_PINF] = exp_ones & ~frac_any & ~sign;
        cls[CL_NINF] = exp_ones & ~frac_any &  sign;
        cls[CL_PZER] = exp_zero & ~frac_any & ~sign;
        cls[CL_NZER] = exp_zero & ~frac_any &  sign;
        cls[CL_PSUB] = exp_zero &  frac_any & ~sign;
        cls[CL_NSUB] = exp_zero &  frac_any &  sign;
    end

endmodule

// File: rtl/fpc_mask_match.sv
module fpc_mask_match
    import fpc_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    input  logic [CLASS_W-1:0] mask,
    output logic               hit
);

    always_comb begin
        hit = |(cls & mask);
    end

endmodule

// File: rtl/fpc_probe.sv
module fpc_probe
    import fpc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           fmt,
    input  logic [127:0]         operand,
    input  logic [6:0]           class_mask,
    output logic                 out_valid,
    output logic [3:0]           cond
);

    logic [NUM_FMT-1:0][CLASS_W-1:0] cls_all;
    logic [NUM_FMT-1:0]              sgn_all;

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW = fmt_exp_w(g);
        localparam int FW = fmt_frac_w(g);
        fpc_field_decode #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_dec (
            .word (operand[EW+FW:0]),
            .cls  (cls_all[g]),
            .sign (sgn_all[g])
        );
    end

    logic [CLASS_W-1:0] cls_sel;
    logic               sgn_sel;
    logic               hit;

    always_comb begin
        case (fmt_e'(fmt))
            FMT_W32: begin cls_sel = cls_all[0]; sgn_sel = sgn_all[0]; end
            FMT_W64: begin cls_sel = cls_all[1]; sgn_sel = sgn_all[1]; end
            default: begin cls_sel = cls_all[2]; sgn_sel = sgn_all[2]; end
        endcase
    end

    fpc_mask_match u_match (
        .cls  (cls_sel),
        .mask (class_mask),
        .hit  (hit)
    );

    probe_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.cond        = '0;
            st_d.cond[CF_LT] = sgn_sel;
            st_d.cond[CF_EQ] = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign cond      = st_q.cond;

endmodule

// File: rtl/fpc_probe_chk.sv
module fpc_probe_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   fmt,
    input logic [127:0] operand,
    input logic [6:0]   class_mask,
    input logic         out_valid,
    input logic [3:0]   cond
);

    logic armed_q;
    logic sgn_in;
    logic nan_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    always_comb begin
        case (fmt)
            2'd0: begin
                sgn_in = operand[31];
                nan_in = (operand[30:23] == 8'hFF) && (operand[22:0] != '0);
            end
            2'd1: begin
                sgn_in = operand[63];
                nan_in = (operand[62:52] == 11'h7FF) && (operand[51:0] != '0);
            end
            default: begin
                sgn_in = operand[127];
                nan_in = (operand[126:112] == 15'h7FFF) && (operand[111:0] != '0);
            end
        endcase
    end

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q) out_valid == $past(in_valid)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q) !in_valid |=> $stable(cond)); // R3
    AST_SIGN_COPY: assert property (@(posedge clk) disable iff (!rst_n || !armed_q) in_valid |=> cond[3] == $past(sgn_in)); // R7
    AST_SPARE_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (cond[2] == 1'b0 && cond[0] == 1'b0)); // R8
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n || !armed_q) (in_valid && class_mask == 7'h00) |=> !cond[1]); // R9
    AST_NAN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !armed_q) (in_valid && nan_in) |=> cond[1] == $past(class_mask[6])); // R10

endmodule

bind fpc_probe fpc_probe_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .fmt        (fmt),
    .operand    (operand),
    .class_mask (class_mask),
    .out_valid  (out_valid),
    .cond       (cond)
);

// File: tb/fpc_probe_bench.sv
module fpc_probe_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   fmt = 2'd0;
    logic [127:0] operand = '0;
    logic [6:0]   class_mask = '0;
    logic         out_valid;
    logic [3:0]   cond;

    always #5 clk = ~clk;

    fpc_probe u_fpc_probe (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .fmt        (fmt),
        .operand    (operand),
        .class_mask (class_mask),
        .out_valid  (out_valid),
        .cond       (cond)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    have_last = 1'b0;
    logic [3:0] last_exp = '0;

    function automatic logic [3:0] ref_cond(logic [1:0] f, logic [127:0] op, logic [6:0] m);
        logic s, ones, zer, fz;
        logic [6:0] c;
        case (f)
            2'd0: begin s = op[31]; ones = op[30:23] == 8'hFF; zer = op[30:23] == 8'h00; fz = op[22:0] == '0; end
            2'd1: begin s = op[63]; ones = op[62:52] == 11'h7FF; zer = op[62:52] == 11'h000; fz = op[51:0] == '0; end
            default: begin s = op[127]; ones = op[126:112] == 15'h7FFF; zer = op[126:112] == 15'h0; fz = op[111:0] == '0; end
        endcase
        c[6] = ones && !fz;
        c[5] = ones && fz && !s;
        c[4] = ones && fz && s;
        c[3] = zer && fz && !s;
        c[2] = zer && fz && s;
        c[1] = zer && !fz && !s;
        c[0] = zer && !fz && s;
        return {s, 1'b0, |(c & m), 1'b0};
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: cond actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic send(logic [1:0] f, logic [127:0] op, logic [6:0] m, string tag);
        item_t it;
        @(posedge clk);
        #1;
        in_valid   = 1'b1;
        fmt        = f;
        operand    = op;
        class_mask = m;
        it.exp = ref_cond(f, op, m);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid   = 1'b0;
            operand    = {4{32'hA5A5_5A5A}};
            class_mask = 7'h7F;
        end
    endtask

    task automatic sweep(logic [1:0] f, logic [127:0] op);
        for (int b = 0; b < 7; b++) send(f, op, 7'(1 << b), "R5 R6 R7");
        send(f, op, 7'h7F, "R9 all-classes");
        send(f, op, 7'h00, "R9 empty-mask");
        idle(2);
    endtask

    // Monitor: samples 3 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (rst_n) begin
                if (out_valid) begin
                    if (sb_q.size() == 0) begin
                        checks++;
                        failures++;
                        $display("FAIL R2: out_valid actual=1 expected=0 (no pending item)");
                    end else begin
                        item_t it;
                        it = sb_q.pop_front();
                        check(it.tag, cond, it.exp);
                        check("R8 spare bits", {cond[2], cond[0]}, 4'b0000 & 4'b0011);
                        last_exp  = it.exp;
                        have_last = 1'b1;
                    end
                end else if (have_last) begin
                    check("R3 hold when idle", cond, last_exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3;
        check("R1 reset cond", cond, 4'b0000);
        check("R1 reset valid", {3'b0, out_valid}, 4'b0000);
        #2;
        rst_n = 1'b1;
        @(posedge clk);
        #3;
        check("R1 after release", {out_valid, 3'b0} | cond, 4'b0000);

        // 32-bit
        sweep(2'd0, 128'h3F80_0000);                 // +1.0 normal
        sweep(2'd0, 128'hFF80_0000);                 // -inf
        sweep(2'd0, 128'h7F80_0000);                 // +inf
        sweep(2'd0, 128'h8000_0000);                 // -0
        sweep(2'd0, 128'h0000_0000);                 // +0
        sweep(2'd0, 128'h0000_0001);                 // +subnormal
        sweep(2'd0, 128'h8040_0000);                 // -subnormal
        sweep(2'd0, 128'hC2F0_0000);                 // -normal
        // 64-bit
        sweep(2'd1, 128'h7FF0_0000_0000_0000);       // +inf
        sweep(2'd1, 128'h000F_FFFF_FFFF_FFFF);       // +subnormal
        sweep(2'd1, 128'hBFF0_0000_0000_0000);       // -1.0
        sweep(2'd1, 128'h8000_0000_0000_0000);       // -0
        // 128-bit
        sweep(2'd2, {16'hFFFF, 112'h0});             // -inf
        sweep(2'd2, {16'h8000, 112'h1});             // -subnormal
        sweep(2'd2, {16'h3FFF, 112'h0});             // +1.0
        sweep(2'd2, {16'h0000, 112'h0});             // +0

        // R10: quiet and signaling NaN in every width
        send(2'd0, 128'h7FC0_0000, 7'h40, "R10 quiet 32");
        send(2'd0, 128'h7F80_0001, 7'h40, "R10 signaling 32");
        send(2'd0, 128'hFF80_0001, 7'h3F, "R10 signaling no other bit");
        send(2'd1, 128'h7FF8_0000_0000_0000, 7'h40, "R10 quiet 64");
        send(2'd1, 128'hFFF0_0000_0000_0001, 7'h40, "R10 signaling 64");
        send(2'd2, {16'h7FFF, 112'h1}, 7'h40, "R10 signaling 128");
        send(2'd2, {16'hFFFF, 1'b1, 111'h0}, 7'h3F, "R10 quiet no other bit");
        idle(3);

        // R4: upper bits ignored, alternate 128-bit code
        send(2'd0, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h7F80_0000}, 7'h20, "R4 upper ignored 32");
        send(2'd0, {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h3F80_0000}, 7'h7F, "R4 upper ignored normal");
        send(2'd1, {64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}, 7'h08, "R4 upper ignored 64");
        send(2'd3, {16'h7FFF, 112'h0}, 7'h20, "R4 code 3 as 128");
        send(2'd3, {16'h0000, 48'h0, 64'h7FF0_0000_0000_0000}, 7'h02, "R4 code 3 subnormal");
        send(2'd2, {16'h3FFF, 48'h0, 64'h7FF0_0000_0000_0000}, 7'h7F, "R4 128 normal");
        idle(4);

        check("R2 queue drained", 4'(sb_q.size()), 4'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule